// File: doc/BRIEF.md
# Shared-Adder Quadrature Position Counter Bank

This block keeps a signed-free position count for a group of quadrature encoder channels without giving each channel its own counter. Every channel's count and its small filter state live in one per-channel store. A slot sequencer visits the channels in a fixed round-robin order. In a channel's slot the block takes that channel's synchronised A, B and index samples and filters them. It then decodes the step and writes back the count through a single shared add/subtract unit, all in one read-modify-write.

One extra cycle at the end of every round is kept free of updates and belongs to the host. A host read presents a channel address and holds a request. The block answers with a ready strobe in the host cycle and returns the stored count and the channel's sticky fault flag directly from the store. No separate readout multiplexer per channel is needed. The core clock is chosen so that one round lasts one channel service period, for example 1 MHz per channel.

Top module: `qenc_bank`

## Requirements
- R1: After reset every channel count is 0 and every fault flag is 0.
- R2: The sequencer runs a round of NUM_CH+1 cycles: update slots for channels 0 to NUM_CH-1 in order, then one host slot; each channel is updated exactly once per round.
- R3: Every raw input passes a two-flop synchroniser. A filtered input takes a new level only after three consecutive equal samples taken in that channel's slots, so a pulse lasting fewer than three samples changes nothing.
- R4: With the filtered pair written {A,B}, the sequence 00, 10, 11, 01, 00 is forward and adds 1 per transition; the reverse sequence subtracts 1 per transition.
- R5: A transition in which A and B both change in the same slot leaves the count unchanged and sets the channel's fault flag.
- R6: The fault flag is sticky across later legal steps. A host read of that channel returns the flag and then clears it.
- R7: A filtered rising edge of the index input sets that channel's count to 0, even when a step is decoded in the same slot; an index held high or falling does not alter the count.
- R8: Counts wrap modulo 2^CNT_W in both directions.
- R9: rd_ready is high only in the host slot while rd_req is high. In that cycle, rd_count and rd_fault show the addressed channel, and a request waits at most NUM_CH+1 cycles.
- R10: Activity on one channel never changes another channel's count or fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, NUM_CH+1 cycles per service round |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | NUM_CH | Raw quadrature A input per channel |
| enc_b | input | NUM_CH | Raw quadrature B input per channel |
| enc_idx | input | NUM_CH | Raw index input per channel |
| rd_req | input | 1 | Host read request, held until rd_ready |
| rd_addr | input | $clog2(NUM_CH) | Channel to read, below NUM_CH |
| rd_ready | output | 1 | Read served in this cycle |
| rd_count | output | CNT_W | Count of the addressed channel |
| rd_fault | output | 1 | Sticky illegal-transition flag of the addressed channel |

## Verification
The bench drives a three-channel, six-bit configuration. It runs full forward and reverse Gray-code walks, including a complete 64-step lap, so the stored count is compared against the arithmetic position modulo 64 at the wrap in both directions. One-sample and two-sample glitches test the three-sample filter, because a filter that accepts them shifts the count. Simultaneous A/B flips separate illegal transitions from steps. An index edge arriving together with a step tests the priority of the clear. Reads spread over all channels after each activity show that one channel's traffic leaves its neighbours untouched and that a read waits no longer than one round.

// File: rtl/qenc_pkg.sv
// Shared types for the quadrature counter bank.
// Assumes the sample vector order {index, A, B} in bits [2:0].
package qenc_pkg;

    localparam int SIG_N   = 3;  // signals per channel
    localparam int SIG_IDX = 2;
    localparam int SIG_A   = 1;
    localparam int SIG_B   = 0;

    // Per-channel filter state: accepted levels and two older raw samples.
    typedef struct packed {
        logic [SIG_N-1:0] filt;
        logic [SIG_N-1:0] hist1;
        logic [SIG_N-1:0] hist2;
    } chan_state_t;

    // Decoder verdict for one slot.
    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2,
        MOVE_BAD  = 2'd3
    } move_t;

endpackage

// File: rtl/qenc_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes each bit is a level that is slow relative to clk; no bus coherence.
module qenc_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic stage1;
        logic stage2;

        // Two register stages per bit to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= d_async[g];
                stage2 <= stage1;
            end
        end

        assign q_sync[g] = stage2;
    end

endmodule

// File: rtl/qenc_slot_seq.sv
// Round-robin slot sequencer: NUM_CH update slots followed by one host slot.
// Assumes NUM_CH >= 2; the round repeats without gaps after reset.
module qenc_slot_seq #(
    parameter int NUM_CH = 8,
    localparam int SW = $clog2(NUM_CH + 1),
    localparam int AW = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot,
    output logic          upd_en,
    output logic          host_en,
    output logic [AW-1:0] ch_idx
);

    localparam logic [SW-1:0] HOST_SLOT = SW'(NUM_CH);

    logic [SW-1:0] slot_q;

    // Advance the slot pointer and wrap after the host slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == HOST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Decode the slot kind and the channel served.
    always_comb begin
        host_en = (slot_q == HOST_SLOT);
        upd_en  = !host_en;
        ch_idx  = upd_en ? slot_q[AW-1:0] : '0;
    end

    assign slot = slot_q;

endmodule

// File: rtl/qenc_chan_update.sv
// Per-slot datapath: three-sample filter, Gray-code step decoder and the
// shared add/subtract unit. Purely combinational; the caller stores results.
// Assumes sample order {index, A, B}.
module qenc_chan_update
    import qenc_pkg::*;
#(
    parameter int CNT_W = 27
) (
    input  chan_state_t      st_old,
    input  logic [CNT_W-1:0] cnt_old,
    input  logic [SIG_N-1:0] sample,
    output chan_state_t      st_new,
    output logic [CNT_W-1:0] cnt_new,
    output logic             fault_set,
    output logic             clear_hit,
    output move_t            move
);

    logic [SIG_N-1:0] filt_new;
    logic [1:0]       pos_old;
    logic [1:0]       pos_new;
    logic [1:0]       pos_diff;
    logic [CNT_W-1:0] delta;

    // Accept a level per signal once three consecutive samples agree.
    always_comb begin
        for (int i = 0; i < SIG_N; i++) begin
            if (sample[i] == st_old.hist1[i] && sample[i] == st_old.hist2[i]) begin
                filt_new[i] = sample[i];
            end else begin
                filt_new[i] = st_old.filt[i];
            end
        end
        st_new.filt  = filt_new;
        st_new.hist1 = sample;
        st_new.hist2 = st_old.hist1;
    end

    // Map {A,B} to a cycle position and classify the difference.
    always_comb begin
        pos_old  = {st_old.filt[SIG_B], st_old.filt[SIG_A] ^ st_old.filt[SIG_B]};
        pos_new  = {filt_new[SIG_B], filt_new[SIG_A] ^ filt_new[SIG_B]};
        pos_diff = pos_new - pos_old;
        unique case (pos_diff)
            2'd1:    move = MOVE_UP;
            2'd3:    move = MOVE_DOWN;
            2'd2:    move = MOVE_BAD;
            default: move = MOVE_NONE;
        endcase
    end

    // Shared adder: clear has priority, then step, else hold.
    always_comb begin
        clear_hit = filt_new[SIG_IDX] && !st_old.filt[SIG_IDX];
        fault_set = (move == MOVE_BAD);
        delta     = (move == MOVE_DOWN) ? '1 : CNT_W'(1);
        if (clear_hit) begin
            cnt_new = '0;
        end else if (move == MOVE_UP || move == MOVE_DOWN) begin
            cnt_new = cnt_old + delta;
        end else begin
            cnt_new = cnt_old;
        end
    end

endmodule

// File: rtl/qenc_bank.sv
// Time-multiplexed quadrature counter bank. One store holds every channel's
// count, filter state and fault flag; one datapath updates a channel per slot;
// the host reads the same store in the reserved host slot.
// Assumes rd_addr < NUM_CH and the host holds rd_req until rd_ready.
module qenc_bank
    import qenc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 27,
    localparam int AW = $clog2(NUM_CH),
    localparam int SW = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] enc_a,
    input  logic [NUM_CH-1:0] enc_b,
    input  logic [NUM_CH-1:0] enc_idx,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_ready,
    output logic [CNT_W-1:0]  rd_count,
    output logic              rd_fault
);

    logic [NUM_CH-1:0] a_s;
    logic [NUM_CH-1:0] b_s;
    logic [NUM_CH-1:0] idx_s;
    logic [SW-1:0]     slot;
    logic              upd_en;
    logic              host_en;
    logic [AW-1:0]     ch_idx;

    logic [CNT_W-1:0]  cnt_mem [NUM_CH];
    chan_state_t       st_mem  [NUM_CH];
    logic [NUM_CH-1:0] fault_q;

    logic [SIG_N-1:0]  sample;
    chan_state_t       st_wr;
    logic [CNT_W-1:0]  cnt_wr;
    logic              fault_set;
    logic              clear_hit;
    move_t             move;

    qenc_sync #(.WIDTH(3 * NUM_CH)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({enc_idx, enc_a, enc_b}),
        .q_sync  ({idx_s, a_s, b_s})
    );

    qenc_slot_seq #(.NUM_CH(NUM_CH)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .upd_en  (upd_en),
        .host_en (host_en),
        .ch_idx  (ch_idx)
    );

    // Pick the synchronised inputs of the channel in its slot.
    always_comb begin
        sample = '0;
        sample[SIG_IDX] = idx_s[ch_idx];
        sample[SIG_A]   = a_s[ch_idx];
        sample[SIG_B]   = b_s[ch_idx];
    end

    qenc_chan_update #(.CNT_W(CNT_W)) i_upd (
        .st_old    (st_mem[ch_idx]),
        .cnt_old   (cnt_mem[ch_idx]),
        .sample    (sample),
        .st_new    (st_wr),
        .cnt_new   (cnt_wr),
        .fault_set (fault_set),
        .clear_hit (clear_hit),
        .move      (move)
    );

    // Write back the count and filter state of the served channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                cnt_mem[i] <= '0;
                st_mem[i]  <= '0;
            end
        end else if (upd_en) begin
            cnt_mem[ch_idx] <= cnt_wr;
            st_mem[ch_idx]  <= st_wr;
        end
    end

    // Set fault flags on illegal steps; clear on a served host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
        end else if (upd_en && fault_set) begin
            fault_q[ch_idx] <= 1'b1;
        end else if (rd_ready) begin
            fault_q[rd_addr] <= 1'b0;
        end
    end

    // Serve reads from the store in the host slot only.
    always_comb begin
        rd_ready = rd_req && host_en;
        rd_count = cnt_mem[rd_addr];
        rd_fault = fault_q[rd_addr];
    end

endmodule

// File: rtl/qenc_bank_chk.sv
// Protocol and sequencing checks for qenc_bank, attached by bind.
module qenc_bank_chk #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 27,
    localparam int AW = $clog2(NUM_CH),
    localparam int SW = $clog2(NUM_CH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SW-1:0]     slot,
    input logic              rd_req,
    input logic              rd_ready,
    input logic [AW-1:0]     rd_addr,
    input logic [NUM_CH-1:0] fault_q,
    input logic              upd_en,
    input logic              clear_hit,
    input logic [CNT_W-1:0]  cnt_wr
);

    localparam logic [SW-1:0] HOST_SLOT = SW'(NUM_CH);

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> rd_req); // R9
    AST_READY_HOST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> slot == HOST_SLOT); // R9
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        slot != HOST_SLOT |=> slot == SW'($past(slot) + 1'b1)); // R2
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        slot == HOST_SLOT |=> slot == '0); // R2
    AST_FAULT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !fault_q[$past(rd_addr)]); // R6
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && clear_hit |-> cnt_wr == '0); // R7

endmodule

bind qenc_bank qenc_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_qenc_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (slot),
    .rd_req    (rd_req),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .fault_q   (fault_q),
    .upd_en    (upd_en),
    .clear_hit (clear_hit),
    .cnt_wr    (cnt_wr)
);

// File: tb/test_qenc_bank.sv
// Bench for qenc_bank: three channels, six-bit counts, expected values
// computed from the Gray-code walk arithmetic.
module test_qenc_bank;

    localparam int NCH   = 3;
    localparam int CW    = 6;
    localparam int MODV  = 1 << CW;
    localparam int ROUND = NCH + 1;
    localparam int SETTLE = 6 * ROUND;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0] enc_a = '0;
    logic [NCH-1:0] enc_b = '0;
    logic [NCH-1:0] enc_idx = '0;
    logic          rd_req = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic          rd_ready;
    logic [CW-1:0] rd_count;
    logic          rd_fault;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    int exp_cnt [NCH];
    bit exp_flt [NCH];

    always #2 clk = ~clk;

    qenc_bank #(.NUM_CH(NCH), .CNT_W(CW)) i_qenc_bank (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_count(rd_count), .rd_fault(rd_fault)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    // Host read: hold request until ready, capture, then release.
    task automatic read_ch(input int ch, output int c, output int f, output int waited);
        @(negedge clk);
        rd_addr = 2'(ch);
        rd_req  = 1'b1;
        waited  = 0;
        while (!rd_ready && waited < 50) begin
            @(negedge clk);
            waited++;
        end
        c = int'(rd_count);
        f = int'(rd_fault);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // Read one channel and compare with the model; the fault model clears.
    task automatic verify(input int ch, input string req);
        int c, f, w;
        read_ch(ch, c, f, w);
        check({req, " count"}, c, exp_cnt[ch]);
        check({req, " fault"}, f, int'(exp_flt[ch]));
        check("R9 wait bound", int'(w <= ROUND), 1);
        exp_flt[ch] = 0;
    endtask

    // Move one channel a Gray step (+1/-1), optionally raising index too.
    task automatic step(input int ch, input int dir, input bit idx);
        logic [1:0] p;
        bit rise;
        p = {enc_b[ch], enc_a[ch] ^ enc_b[ch]};
        p = p + 2'(dir);
        rise = idx && !enc_idx[ch];
        enc_b[ch] = p[1];
        enc_a[ch] = p[0] ^ p[1];
        enc_idx[ch] = idx;
        settle();
        exp_cnt[ch] = rise ? 0 : (exp_cnt[ch] + dir + MODV) % MODV;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            exp_cnt[i] = 0;
            exp_flt[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state on every channel
        for (int i = 0; i < NCH; i++) verify(i, "R1");

        // R4 forward walk on channel 0; R10 neighbours untouched
        for (int k = 0; k < 10; k++) step(0, 1, 0);
        verify(0, "R4 fwd");
        verify(1, "R10");
        verify(2, "R10");

        // R4 and R8 reverse walk through zero on channel 1
        for (int k = 0; k < 3; k++) step(1, -1, 0);
        verify(1, "R8 down wrap");
        verify(0, "R10");

        // R8 full lap on channel 2
        for (int k = 0; k < MODV - 1; k++) step(2, 1, 0);
        verify(2, "R8 top");
        step(2, 1, 0);
        verify(2, "R8 up wrap");

        // R3 one-sample and two-sample glitches on A of channel 0
        for (int len = 1; len <= 2; len++) begin
            enc_a[0] = ~enc_a[0];
            repeat (len * ROUND) @(negedge clk);
            enc_a[0] = ~enc_a[0];
            settle();
            verify(0, "R3 glitch");
        end

        // R5 illegal double change, R6 sticky across a legal step
        enc_a[0] = ~enc_a[0];
        enc_b[0] = ~enc_b[0];
        settle();
        exp_flt[0] = 1;
        step(0, 1, 0);
        verify(0, "R6 sticky");
        verify(0, "R6 cleared");
        verify(1, "R10 fault");

        // R5 count unchanged by illegal change
        enc_a[1] = ~enc_a[1];
        enc_b[1] = ~enc_b[1];
        settle();
        exp_flt[1] = 1;
        verify(1, "R5");

        // R7 index edge clears, held high counts, falling edge no effect
        step(1, 1, 1);
        verify(1, "R7 priority");
        step(1, -1, 1);
        step(1, -1, 1);
        verify(1, "R7 held");
        enc_idx[1] = 1'b0;
        settle();
        verify(1, "R7 fall");
        enc_idx[0] = 1'b1;
        settle();
        exp_cnt[0] = 0;
        verify(0, "R7 clear");
        verify(2, "R10 idx");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule